// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers interrupt events from eleven second-level groups and folds them into one interrupt request line. Each group owns four 32-bit registers. The first shows the live event level. The second blocks events per bit. The third records events that got through, and software clears it by writing ones. The fourth selects which recorded bits count as pending.

A fixed routing table reduces each group's pending word (recorded AND selected) onto single bits of a master register. Some groups feed two master bits, one for the low half-word and one for the high half-word. The top bit of the master register is the only bit software can write, and it acts as a global enable. While that bit is clear, the summary bits are frozen and the request line stays low.

Software reaches every register through a simple address, write-data and write-strobe port. Reads return data combinationally from the addressed register. Event sources drive one-cycle pulses, with one 32-bit vector per group.

Top module: `irqagg_top`

## Requirements
- R1: After reset every group's mask register reads 0xFFFFFFFF. Every identity register, every enable register and the master register read 0, and `irq_o` is low.
- R2: Group g (0..10) occupies addresses g*0x10 to g*0x10+0xF. Its status register is at +0x0, mask at +0x4, identity at +0x8 and enable at +0xC. The master register is at 0xB0. Address bits [1:0] are ignored, and any other address reads 0.
- R3: The status register reads the current level of the group's event vector. Writes to it have no effect.
- R4: An event bit whose mask bit is 1 is dropped. An event bit whose mask bit is 0 sets the matching identity bit at the next clock edge. The identity bit then stays set until software clears it.
- R5: Writing the identity register clears each bit written as 1 and keeps each bit written as 0. If an unmasked event hits a bit in the same cycle as the write, the event wins and the bit stays set.
- R6: A write to a mask or enable register replaces the whole 32-bit value.
- R7: While the global enable is 1, each master summary bit is updated one clock after the state it depends on. It is set when (identity AND enable AND entry mask) of its source group is nonzero, and cleared otherwise.
- R8: Routing table. Group 0 bits [15:0] feed master bit 0 and bits [31:16] feed bit 1. Group 1 bits [15:0] feed bit 2 and bits [31:16] feed bit 3. Group 2 bits [15:0] feed bit 4. Group 3 bits [15:0] feed bit 6. The high halves of groups 2 and 3 feed nothing. Groups 4, 5, 6, 7, 8, 9 and 10 feed bits 16, 17, 18, 20, 22, 23 and 30 with all 32 bits.
- R9: Master bit 31 is the global enable and takes `wdata[31]` on a master write. A master write leaves bits [30:0] unchanged.
- R10: While the global enable is 0, the master summary bits hold their values and `irq_o` is low. While it is 1, `irq_o` is high exactly when any of master bits [30:0] is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W (8) | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| ev_i | input | 11*32 | Event pulses, group g in bits [g*32+31:g*32] |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
The hardest state to reach from the ports is a summary bit that stays set after its source condition is gone. Reaching it takes four steps in order. First, unmask the group, enable it and inject an event while the global enable is 1, so that the summary bit gets set. Next, clear the global enable. Then clear the identity bit. Finally, re-enable and watch the summary bit clear one clock later. Two other cases need careful stimulus. The collision between a clearing write and a new event needs the strobe and the pulse driven in the same cycle. The high half-words of groups 2 and 3 have no route, and the bench shows they reach no master bit.

// File: rtl/irqagg_pkg.sv
// Shared constants, register selector type and the group-to-master routing table.
package irqagg_pkg;

    localparam int WORD_W        = 32;
    localparam int NUM_GROUPS    = 11;
    localparam int GRP_SPAN_LSB  = 4;                 // each group spans 16 bytes
    localparam int GLOBAL_EN_BIT = WORD_W - 1;
    localparam int SUMM_W        = WORD_W - 1;
    localparam int NUM_ROUTES    = 13;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_IDENT  = 2'd2,
        REG_ENABLE = 2'd3
    } reg_sel_e;

    // Routing table: source group, master bit, and which source bits count.
    localparam int ROUTE_SRC [NUM_ROUTES] = '{0, 0, 1, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10};
    localparam int ROUTE_BIT [NUM_ROUTES] = '{0, 1, 2, 3, 4, 6, 16, 17, 18, 20, 22, 23, 30};
    localparam logic [WORD_W-1:0] ROUTE_MASK [NUM_ROUTES] = '{
        32'h0000FFFF, 32'hFFFF0000, 32'h0000FFFF, 32'hFFFF0000,
        32'h0000FFFF, 32'h0000FFFF,
        32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
        32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF
    };

endpackage

// File: rtl/irqagg_group.sv
// irqagg_group: mask, identity and enable registers of one second-level group.
// Assumes ev is a pulse vector already synchronous to clk. An event in the
// same cycle as a clearing write to the identity register wins.
module irqagg_group
    import irqagg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_hit,
    input  reg_sel_e wr_reg,
    input  word_t    wdata,
    input  word_t    ev,
    output word_t    mask_q,
    output word_t    ident_q,
    output word_t    enable_q
);

    word_t clr_bits;
    word_t new_bits;

    // Bits to clear from a write-one-to-clear access, and bits that passed the mask.
    always_comb begin
        clr_bits = (wr_hit && wr_reg == REG_IDENT) ? wdata : '0;
        new_bits = ev & ~mask_q;
    end

    // Mask register: full replacement on write, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr_hit && wr_reg == REG_MASK)
            mask_q <= wdata;
    end

    // Enable register: full replacement on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (wr_hit && wr_reg == REG_ENABLE)
            enable_q <= wdata;
    end

    // Identity register: sticky latch of unmasked events, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ident_q <= '0;
        else
            ident_q <= (ident_q & ~clr_bits) | new_bits;
    end

endmodule

// File: rtl/irqagg_summary.sv
// irqagg_summary: reduces group pending words through the routing table onto
// the master register and drives the request line. Summary bits update only
// while the global enable is set; otherwise they hold.
module irqagg_summary
    import irqagg_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         master_wr,
    input  word_t                        wdata,
    input  logic [NUM_GROUPS-1:0][WORD_W-1:0] pend,
    output word_t                        master_q,
    output logic                         irq_o
);

    logic [NUM_ROUTES-1:0] route_hit;
    logic [SUMM_W-1:0]     summ_nxt;
    logic [SUMM_W-1:0]     summ_q;
    logic                  gen_en_q;

    // One reduction per routing entry.
    for (genvar e = 0; e < NUM_ROUTES; e++) begin : g_route
        assign route_hit[e] = |(pend[ROUTE_SRC[e]] & ROUTE_MASK[e]);
    end

    // Scatter the entry results onto their master bit positions.
    always_comb begin
        summ_nxt = '0;
        for (int e = 0; e < NUM_ROUTES; e++) begin
            if (route_hit[e])
                summ_nxt[ROUTE_BIT[e]] = 1'b1;
        end
    end

    // Global enable: the only software-writable master bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gen_en_q <= 1'b0;
        else if (master_wr)
            gen_en_q <= wdata[GLOBAL_EN_BIT];
    end

    // Summary bits follow the pending state level-wise while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            summ_q <= '0;
        else if (gen_en_q)
            summ_q <= summ_nxt;
    end

    assign master_q = {gen_en_q, summ_q};
    assign irq_o    = gen_en_q && (summ_q != '0);

endmodule

// File: rtl/irqagg_top.sv
// irqagg_top: two-level interrupt aggregator with a flat register port.
// Assumes word-aligned accesses; addr[1:0] is ignored. Reads are combinational.
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [WORD_W-1:0]            wdata,
    output logic [WORD_W-1:0]            rdata,
    input  logic [NUM_GROUPS*WORD_W-1:0] ev_i,
    output logic                         irq_o
);

    localparam int GRP_IDX_W = ADDR_W - GRP_SPAN_LSB;
    localparam logic [GRP_IDX_W-1:0] MASTER_IDX = GRP_IDX_W'(NUM_GROUPS);

    logic [GRP_IDX_W-1:0] grp_idx;
    reg_sel_e             reg_sel;
    logic [NUM_GROUPS-1:0][WORD_W-1:0] ev_w;
    logic [NUM_GROUPS-1:0][WORD_W-1:0] mask_w;
    logic [NUM_GROUPS-1:0][WORD_W-1:0] ident_w;
    logic [NUM_GROUPS-1:0][WORD_W-1:0] enable_w;
    logic [NUM_GROUPS-1:0][WORD_W-1:0] pend_w;
    word_t                master_w;
    logic                 master_wr;

    assign grp_idx   = addr[ADDR_W-1:GRP_SPAN_LSB];
    assign reg_sel   = reg_sel_e'(addr[3:2]);
    assign ev_w      = ev_i;
    assign master_wr = wr_en && (grp_idx == MASTER_IDX) && (reg_sel == REG_STATUS);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit;
        assign hit = wr_en && (grp_idx == GRP_IDX_W'(g));

        irqagg_group u_group (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hit),
            .wr_reg   (reg_sel),
            .wdata    (wdata),
            .ev       (ev_w[g]),
            .mask_q   (mask_w[g]),
            .ident_q  (ident_w[g]),
            .enable_q (enable_w[g])
        );

        assign pend_w[g] = ident_w[g] & enable_w[g];
    end

    irqagg_summary u_summary (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_wr (master_wr),
        .wdata     (wdata),
        .pend      (pend_w),
        .master_q  (master_w),
        .irq_o     (irq_o)
    );

    // Read multiplexer over the group registers and the master register.
    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_idx == GRP_IDX_W'(g)) begin
                case (reg_sel)
                    REG_STATUS: rdata = ev_w[g];
                    REG_MASK:   rdata = mask_w[g];
                    REG_IDENT:  rdata = ident_w[g];
                    REG_ENABLE: rdata = enable_w[g];
                    default:    rdata = '0;
                endcase
            end
        end
        if (grp_idx == MASTER_IDX && reg_sel == REG_STATUS)
            rdata = master_w;
    end

endmodule

// File: rtl/irqagg_checker.sv
// irqagg_checker: temporal properties on group 0 and the master path.
// Bound into irqagg_top; observes only, drives nothing.
module irqagg_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       ev0,
    input logic [31:0]       mask0,
    input logic [31:0]       ident0,
    input logic              gen_en,
    input logic [30:0]       summ,
    input logic              irq_o
);

    localparam logic [ADDR_W-3:0] MASK0_WORD  = (ADDR_W-2)'(1);
    localparam logic [ADDR_W-3:0] IDENT0_WORD = (ADDR_W-2)'(2);

    // R4: identity bits rise only where an unmasked event arrived.
    a_r4_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        ((ident0 & ~$past(ident0)) & ~$past(ev0 & ~mask0)) == 32'h0);

    // R5: bits written as one are gone next cycle unless an event re-set them.
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1:2] == IDENT0_WORD) |=>
        ((ident0 & $past(wdata) & ~$past(ev0 & ~mask0)) == 32'h0));

    // R6: a mask write replaces the whole register.
    a_r6_mask_replace: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1:2] == MASK0_WORD) |=> (mask0 == $past(wdata)));

    // R10: summary bits hold while the global enable is clear.
    a_r10_summary_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> $stable(summ));

    // R10: no request without the global enable.
    a_r10_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gen_en);

endmodule

bind irqagg_top irqagg_checker #(.ADDR_W(ADDR_W)) u_irqagg_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .ev0    (ev_i[31:0]),
    .mask0  (mask_w[0]),
    .ident0 (ident_w[0]),
    .gen_en (master_w[31]),
    .summ   (master_w[30:0]),
    .irq_o  (irq_o)
);

// File: tb/irqagg_top_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, a monitor compares them.
module irqagg_top_bench;

    localparam int NG = 11;
    localparam logic [7:0] MASTER_A = 8'hB0;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic [NG-1:0][31:0] ev = '0;
    logic             irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] exp_q[$];
    bit          kind_q[$];
    string       tag_q[$];
    event        mon_ev;

    always #2.5 clk = ~clk;

    irqagg_top u_irqagg_top (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .ev_i  (ev),
        .irq_o (irq_o)
    );

    function automatic logic [7:0] gbase(input int g);
        return 8'(g * 16);
    endfunction

    // Master bit fed by group g, half hi; -1 when there is no route.
    function automatic int route_of(input int g, input bit hi);
        case (g)
            0: return hi ? 1 : 0;
            1: return hi ? 3 : 2;
            2: return hi ? -1 : 4;
            3: return hi ? -1 : 6;
            4: return 16;
            5: return 17;
            6: return 18;
            7: return 20;
            8: return 22;
            9: return 23;
            default: return 30;
        endcase
    endfunction

    // Monitor: pops one expected item per request and compares away from the edge.
    initial begin
        forever begin
            logic [31:0] act;
            logic [31:0] e;
            bit k;
            string t;
            @(mon_ev);
            #1;
            e = exp_q.pop_front();
            k = kind_q.pop_front();
            t = tag_q.pop_front();
            act = k ? {31'b0, irq_o} : rdata;
            n_tests++;
            if (act !== e) begin
                n_fail++;
                $display("FAIL %s: actual %08h expected %08h", t, act, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        addr = a;
        exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
        -> mon_ev;
        #2;
    endtask

    task automatic chk_irq(input bit e, input string t);
        @(negedge clk);
        exp_q.push_back({31'b0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
        -> mon_ev;
        #2;
    endtask

    task automatic pulse(input int g, input logic [31:0] v);
        @(negedge clk);
        ev[g] = v;
        @(negedge clk);
        ev[g] = '0;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(gbase(0) + 8'h4, 32'hFFFFFFFF, "R1 mask g0");
        rd(gbase(10) + 8'h4, 32'hFFFFFFFF, "R1 mask g10");
        rd(gbase(0) + 8'h8, 32'h0, "R1 ident g0");
        rd(gbase(0) + 8'hC, 32'h0, "R1 enable g0");
        rd(MASTER_A, 32'h0, "R1 master");
        chk_irq(1'b0, "R1 irq");

        // R4 masked event dropped
        pulse(0, 32'h1);
        rd(gbase(0) + 8'h8, 32'h0, "R4 masked drop");

        // R6 full replace, R4 unmasked latch
        wr(gbase(0) + 8'h4, 32'h0);
        rd(gbase(0) + 8'h4, 32'h0, "R6 mask replace");
        wr(gbase(0) + 8'hC, 32'hFFFFFFFF);
        rd(gbase(0) + 8'hC, 32'hFFFFFFFF, "R6 enable replace");
        pulse(0, 32'h8);
        rd(gbase(0) + 8'h8, 32'h8, "R4 latch");
        rd(gbase(0) + 8'h8, 32'h8, "R4 sticky");

        // R3 status mirrors level, writes ignored
        @(negedge clk); ev[1] = 32'h55;
        rd(gbase(1), 32'h55, "R3 status level");
        wr(gbase(1), 32'hFFFF);
        rd(gbase(1), 32'h55, "R3 status write ignored");
        @(negedge clk); ev[1] = '0;
        rd(gbase(1), 32'h0, "R3 status follows");

        // R10 disabled: nothing propagates
        rd(MASTER_A, 32'h0, "R10 no propagation when off");
        chk_irq(1'b0, "R10 irq off");

        // R9 enable, R8 group 0 low half, R10 irq
        wr(MASTER_A, 32'hFFFFFFFF);
        rd(MASTER_A, 32'h80000001, "R9 R8 master after enable");
        chk_irq(1'b1, "R10 irq on");

        // R5 clear, R7 summary follows down
        wr(gbase(0) + 8'h8, 32'h8);
        rd(gbase(0) + 8'h8, 32'h0, "R5 w1c");
        rd(MASTER_A, 32'h80000000, "R7 summary clears");
        chk_irq(1'b0, "R10 irq drops");

        // R5 partial clear
        pulse(0, 32'h3);
        wr(gbase(0) + 8'h8, 32'h1);
        rd(gbase(0) + 8'h8, 32'h2, "R5 partial w1c");
        wr(gbase(0) + 8'h8, 32'hFFFFFFFF);

        // R7 enable gating of a high-half bit
        wr(gbase(0) + 8'hC, 32'h0000FFFF);
        pulse(0, 32'h00100000);
        rd(MASTER_A, 32'h80000000, "R7 enable gates pending");
        wr(gbase(0) + 8'hC, 32'hFFFFFFFF);
        rd(MASTER_A, 32'h80000002, "R7 enable opens pending");
        wr(gbase(0) + 8'h8, 32'hFFFFFFFF);

        // R5 event wins against same-cycle clear
        @(negedge clk);
        ev[0] = 32'h20; addr = gbase(0) + 8'h8; wdata = 32'h20; wr_en = 1'b1;
        @(negedge clk);
        ev[0] = '0; wr_en = 1'b0;
        rd(gbase(0) + 8'h8, 32'h20, "R5 event beats clear");
        wr(gbase(0) + 8'h8, 32'hFFFFFFFF);

        // R8 routing table, both halves of every group
        for (int g = 0; g < NG; g++) begin
            wr(gbase(g) + 8'h4, 32'h0);
            wr(gbase(g) + 8'hC, 32'hFFFFFFFF);
            for (int h = 0; h < 2; h++) begin
                int b;
                b = route_of(g, h[0]);
                pulse(g, h ? 32'h00020000 : 32'h00000002);
                rd(MASTER_A, 32'h80000000 | (b >= 0 ? (32'h1 << b) : 32'h0),
                   $sformatf("R8 group %0d half %0d", g, h));
                wr(gbase(g) + 8'h8, 32'hFFFFFFFF);
                rd(MASTER_A, 32'h80000000, $sformatf("R7 group %0d cleared", g));
            end
        end

        // R9 master write keeps summary bits; R10 hold while off
        pulse(4, 32'h1);
        rd(MASTER_A, 32'h80010000, "R8 group 4 pending");
        wr(MASTER_A, 32'h80000000);
        rd(MASTER_A, 32'h80010000, "R9 summary untouched by write");
        wr(MASTER_A, 32'h0);
        rd(MASTER_A, 32'h00010000, "R9 only bit 31 writable");
        chk_irq(1'b0, "R10 irq low when off");
        wr(gbase(4) + 8'h8, 32'hFFFFFFFF);
        rd(MASTER_A, 32'h00010000, "R10 summary holds when off");
        wr(MASTER_A, 32'h80000000);
        rd(MASTER_A, 32'h80000000, "R10 summary refreshes on enable");
        chk_irq(1'b0, "R10 irq after refresh");

        // R2 unmapped addresses
        rd(8'hB4, 32'h0, "R2 unmapped after master");
        rd(8'hF0, 32'h0, "R2 unmapped top");
        rd(gbase(0) + 8'h5, 32'h0, "R2 low address bits ignored");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule